// File: doc/BRIEF.md
# Synchronous Microcontroller Bus Slave

This block is a clocked 16-bit slave port. An external microcontroller uses it to read and write an internal register space. A bus transfer opens with a one-cycle start strobe. Address, active-low high-byte enable and the read/write direction are sampled in that same cycle. Chip select is accepted either in the strobe cycle or in the cycle after it, and no configuration is needed to choose between the two. For writes, a static configuration input decides whether the data is taken in the chip-select cycle or in the cycle after it.

Internally the block raises a request with a word address, byte enables and write data. It holds that request until a grant arrives, and the grant may come after any number of cycles. It then answers the master with a one-cycle transfer acknowledge. For a read, the data goes out in the same cycle as the acknowledge. An access to an odd address without the high byte enabled is refused. Such an access issues no internal request, still receives an acknowledge, and adds one to a saturating error counter.

A readiness output keeps the whole bus side undriven until an external load-done indication has been seen.

Top module: `mcu_sync_slave`

## Requirements
- R1: `ready_o` is low after reset and rises one cycle after `load_done_i` is first seen high. Once high it stays high. While it is low, `bus_ta_oe_o` and `bus_rdata_oe_o` are low and start strobes are ignored: no acknowledge and no internal request.
- R2: Address, `bus_bhe_n_i` and `bus_rnw_i` are taken only in the start-strobe cycle. Their values in later cycles have no effect on the transfer.
- R3: Chip select is accepted in the strobe cycle (cycle 0) or in cycle 1. If it is seen in neither, the transfer is dropped with no acknowledge and no internal request.
- R4: With `cfg_wdata_late_i`=0, write data is taken in the chip-select cycle. With it set to 1, write data is taken in the cycle after the chip-select cycle.
- R5: `bus_ta_o` is high for exactly one cycle per accepted transfer. The cycles are counted from the strobe cycle as 0, with d the chip-select cycle and L the number of request cycles before the grant. For a valid access the request starts at r = d+1, or d+2 for a late-data write, and the acknowledge comes in cycle r+L+1. For an erroneous access the acknowledge comes in cycle d+1.
- R6: Read data appears on `bus_rdata_o` in the acknowledge cycle. Byte lanes that are not enabled read as zero, and the output is zero outside the acknowledge.
- R7: Byte enables: bit 0 (bits 7:0) is set when address bit 0 = 0, and bit 1 (bits 15:8) is set when `bus_bhe_n_i` = 0. Only enabled lanes are written internally. `reg_addr_o` is the address without bit 0.
- R8: With `cfg_rd16_i`=1, every valid read uses byte enables 2'b11 and returns all 16 bits. Writes are unaffected.
- R9: An access with address bit 0 = 1 and `bus_bhe_n_i` = 1 issues no internal request, returns zero read data, and increments `err_cnt_o` by one.
- R10: `err_cnt_o` saturates at 255. `err_clr_i` clears it to zero on the next cycle and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_done_i | input | 1 | External indication that the interface may go operational |
| cfg_wdata_late_i | input | 1 | 1: write data valid one cycle after chip select |
| cfg_rd16_i | input | 1 | 1: every read is a full 16-bit access |
| err_clr_i | input | 1 | Clears the error counter |
| bus_ts_i | input | 1 | Transfer start strobe |
| bus_cs_i | input | 1 | Chip select |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_bhe_n_i | input | 1 | Active-low high-byte enable |
| bus_rnw_i | input | 1 | 1 read, 0 write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| bus_rdata_oe_o | output | 1 | Drive enable for read data |
| bus_ta_o | output | 1 | Transfer acknowledge |
| bus_ta_oe_o | output | 1 | Drive enable for the acknowledge |
| ready_o | output | 1 | Interface operational |
| reg_req_o | output | 1 | Internal access request |
| reg_we_o | output | 1 | Internal write |
| reg_addr_o | output | ADDR_W-1 | Internal word address |
| reg_be_o | output | 2 | Internal byte enables |
| reg_wdata_o | output | 16 | Internal write data |
| reg_gnt_i | input | 1 | Internal access complete |
| reg_rdata_i | input | 16 | Internal read data, valid with grant |
| err_cnt_o | output | 8 | Access-error count |

## Verification
The hardest situation to reach is the interplay of a late chip select with late write data and a slow grant. Here a transfer stretches over several cycles while the bus pins already carry unrelated values. The stimulus drives every transfer cycle by cycle. After the strobe cycle it inverts address, high-byte enable and direction, and it puts inverted data on the write bus in every cycle except the one that R4 selects. Any capture in the wrong cycle therefore corrupts a later read-back. Counter saturation is reached with a loop of several hundred erroneous accesses.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CSWAIT = 3'd1,
        ST_DWAIT  = 3'd2,
        ST_REQ    = 3'd3,
        ST_ACK    = 3'd4
    } mbs_state_e;

endpackage

// File: rtl/mbs_lane_decode.sv
module mbs_lane_decode
    import mbs_pkg::*;
(
    input  logic             a0_i,
    input  logic             bhe_n_i,
    input  logic             rnw_i,
    input  logic             rd16_i,
    output logic [LANES-1:0] be_o,
    output logic             err_o
);

    logic full_read;

    always_comb begin
        full_read = rnw_i && rd16_i;
        be_o[0]   = full_read || !a0_i;
        be_o[1]   = full_read || !bhe_n_i;
        err_o     = a0_i && bhe_n_i;
    end

endmodule

// File: rtl/mbs_err_counter.sv
module mbs_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX) && !clr_i |=> (cnt_o == CNT_MAX)); // R10
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !inc_i |=> $stable(cnt_o)); // R9

endmodule

// File: rtl/mcu_sync_slave.sv
module mcu_sync_slave
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_done_i,
    input  logic                cfg_wdata_late_i,
    input  logic                cfg_rd16_i,
    input  logic                err_clr_i,
    input  logic                bus_ts_i,
    input  logic                bus_cs_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_bhe_n_i,
    input  logic                bus_rnw_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                bus_rdata_oe_o,
    output logic                bus_ta_o,
    output logic                bus_ta_oe_o,
    output logic                ready_o,
    output logic                reg_req_o,
    output logic                reg_we_o,
    output logic [ADDR_W-2:0]   reg_addr_o,
    output logic [LANES-1:0]    reg_be_o,
    output logic [DATA_W-1:0]   reg_wdata_o,
    input  logic                reg_gnt_i,
    input  logic [DATA_W-1:0]   reg_rdata_i,
    output logic [CNT_W-1:0]    err_cnt_o
);

    localparam int WADDR_W = ADDR_W - 1;

    typedef struct packed {
        mbs_state_e           st;
        logic                 ready;
        logic [WADDR_W-1:0]   waddr;
        logic                 a0;
        logic                 bhe_n;
        logic                 rnw;
        logic [DATA_W-1:0]    wdata;
        logic [DATA_W-1:0]    rdata;
    } slave_regs_t;

    slave_regs_t r_d, r_q;

    // Attribute source: live pins in the strobe cycle, captured copy afterwards
    logic             in_idle;
    logic             dec_a0, dec_bhe_n, dec_rnw;
    logic [LANES-1:0] dec_be;
    logic             dec_err;
    logic             cs_hit;
    logic             err_inc;
    logic [DATA_W-1:0] rd_masked;

    always_comb begin
        in_idle   = (r_q.st == ST_IDLE);
        dec_a0    = in_idle ? bus_addr_i[0] : r_q.a0;
        dec_bhe_n = in_idle ? bus_bhe_n_i   : r_q.bhe_n;
        dec_rnw   = in_idle ? bus_rnw_i     : r_q.rnw;
        cs_hit    = bus_cs_i &&
                    ((in_idle && r_q.ready && bus_ts_i) || (r_q.st == ST_CSWAIT));
        err_inc   = cs_hit && dec_err;
    end

    mbs_lane_decode u_decode (
        .a0_i    (dec_a0),
        .bhe_n_i (dec_bhe_n),
        .rnw_i   (dec_rnw),
        .rd16_i  (cfg_rd16_i),
        .be_o    (dec_be),
        .err_o   (dec_err)
    );

    mbs_err_counter #(.CNT_W(CNT_W)) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (err_inc),
        .clr_i (err_clr_i),
        .cnt_o (err_cnt_o)
    );

    // Per-lane masking of returned read data
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_masked[g*LANE_W +: LANE_W] =
            dec_be[g] ? reg_rdata_i[g*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        r_d       = r_q;
        r_d.ready = r_q.ready | load_done_i;

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.ready && bus_ts_i) begin
                    r_d.waddr = bus_addr_i[ADDR_W-1:1];
                    r_d.a0    = bus_addr_i[0];
                    r_d.bhe_n = bus_bhe_n_i;
                    r_d.rnw   = bus_rnw_i;
                    r_d.st    = ST_CSWAIT;
                end
            end
            ST_CSWAIT: begin
                if (!bus_cs_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_DWAIT: begin
                r_d.wdata = bus_wdata_i;
                r_d.st    = ST_REQ;
            end
            ST_REQ: begin
                if (reg_gnt_i) begin
                    r_d.rdata = r_q.rnw ? rd_masked : '0;
                    r_d.st    = ST_ACK;
                end
            end
            ST_ACK: begin
                r_d.rdata = '0;
                r_d.st    = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        if (cs_hit) begin
            if (dec_err) begin
                r_d.rdata = '0;
                r_d.st    = ST_ACK;
            end else if (!dec_rnw && !cfg_wdata_late_i) begin
                r_d.wdata = bus_wdata_i;
                r_d.st    = ST_REQ;
            end else if (!dec_rnw) begin
                r_d.st = ST_DWAIT;
            end else begin
                r_d.st = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ready_o        = r_q.ready;
        bus_ta_oe_o    = r_q.ready;
        bus_ta_o       = (r_q.st == ST_ACK);
        bus_rdata_oe_o = r_q.ready && (r_q.st == ST_ACK) && r_q.rnw;
        bus_rdata_o    = r_q.rdata;
        reg_req_o      = (r_q.st == ST_REQ);
        reg_we_o       = reg_req_o && !r_q.rnw;
        reg_addr_o     = r_q.waddr;
        reg_be_o       = reg_req_o ? dec_be : '0;
        reg_wdata_o    = r_q.wdata;
    end

    AST_TA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ta_o |=> !bus_ta_o); // R5
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R1
    AST_NO_REQ_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> !reg_req_o && !bus_ta_o); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_o && !reg_gnt_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_wdata_o)); // R5
    AST_REQ_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_o |-> (reg_be_o != '0)); // R7
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_inc |=> !reg_req_o && bus_ta_o); // R9
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ta_o |-> (bus_rdata_o == '0)); // R6

endmodule

// File: tb/mcu_sync_slave_bench.sv
module mcu_sync_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WORDS = 1 << (AW - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_done_i = 1'b0, cfg_wdata_late_i = 1'b0, cfg_rd16_i = 1'b0, err_clr_i = 1'b0;
    logic bus_ts_i = 1'b0, bus_cs_i = 1'b0, bus_bhe_n_i = 1'b1, bus_rnw_i = 1'b1;
    logic [AW-1:0] bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic bus_rdata_oe_o, bus_ta_o, bus_ta_oe_o, ready_o;
    logic reg_req_o, reg_we_o;
    logic [AW-2:0] reg_addr_o;
    logic [1:0] reg_be_o;
    logic [15:0] reg_wdata_o, reg_rdata_i;
    logic reg_gnt_i = 1'b0;
    logic [7:0] err_cnt_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_sync_slave #(.ADDR_W(AW), .CNT_W(8)) u_mcu_sync_slave (
        .clk(clk), .rst_n(rst_n), .load_done_i(load_done_i),
        .cfg_wdata_late_i(cfg_wdata_late_i), .cfg_rd16_i(cfg_rd16_i), .err_clr_i(err_clr_i),
        .bus_ts_i(bus_ts_i), .bus_cs_i(bus_cs_i), .bus_addr_i(bus_addr_i),
        .bus_bhe_n_i(bus_bhe_n_i), .bus_rnw_i(bus_rnw_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .bus_rdata_oe_o(bus_rdata_oe_o), .bus_ta_o(bus_ta_o),
        .bus_ta_oe_o(bus_ta_oe_o), .ready_o(ready_o), .reg_req_o(reg_req_o),
        .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .reg_be_o(reg_be_o),
        .reg_wdata_o(reg_wdata_o), .reg_gnt_i(reg_gnt_i), .reg_rdata_i(reg_rdata_i),
        .err_cnt_o(err_cnt_o)
    );

    // Internal register space responder with programmable grant latency
    logic [15:0] mem [WORDS];
    int rsp_lat = 0;
    int req_age = 0;

    assign reg_rdata_i = mem[reg_addr_o];

    always @(negedge clk) begin
        if (reg_req_o) begin
            reg_gnt_i <= (req_age == rsp_lat);
            req_age   <= req_age + 1;
        end else begin
            reg_gnt_i <= 1'b0;
            req_age   <= 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hA500 ^ 16'(i);
        end else if (reg_req_o && reg_gnt_i && reg_we_o) begin
            if (reg_be_o[0]) mem[reg_addr_o][7:0]  <= reg_wdata_o[7:0];
            if (reg_be_o[1]) mem[reg_addr_o][15:8] <= reg_wdata_o[15:8];
        end
    end

    // Reference model
    logic [15:0] model_mem [WORDS];
    int  model_err = 0;
    bit  model_ready = 0;
    int  n_chk = 0;
    int  n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] lanes(input bit a0, input bit bhe_n, input bit rnw, input bit rd16);
        if (rnw && rd16) return 2'b11;
        return {~bhe_n, ~a0};
    endfunction

    task automatic xfer(input bit rnw, input logic [AW-1:0] addr, input bit bhe_n,
                        input logic [15:0] wd, input int csdly, input bit late,
                        input bit rd16, input int lat, input string tag);
        bit err, drop;
        int exp_k, ta_n, ta_k, req_n, r;
        logic [1:0] be;
        logic [15:0] got, exp_rd;
        int wk;
        err  = addr[0] && bhe_n;
        drop = !model_ready || (csdly > 1);
        be   = lanes(addr[0], bhe_n, rnw, rd16);
        r    = csdly + 1 + ((!rnw && late) ? 1 : 0);
        exp_k = drop ? -1 : (err ? csdly + 1 : r + lat + 1);
        wk   = csdly + (late ? 1 : 0);
        exp_rd = 16'h0;
        if (!drop && !err && rnw) begin
            exp_rd[7:0]  = be[0] ? model_mem[addr[AW-1:1]][7:0]  : 8'h00;
            exp_rd[15:8] = be[1] ? model_mem[addr[AW-1:1]][15:8] : 8'h00;
        end
        ta_n = 0; ta_k = -1; req_n = 0; got = 16'h0;
        cfg_wdata_late_i = late;
        cfg_rd16_i = rd16;
        rsp_lat = lat;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (k > 0) begin
                if (bus_ta_o) begin ta_n++; ta_k = k; got = bus_rdata_o; end
                if (reg_req_o) req_n++;
            end
            bus_ts_i    = (k == 0);
            bus_cs_i    = (k == csdly);
            bus_addr_i  = (k == 0) ? addr : ~addr;        // R2 scrambled later
            bus_bhe_n_i = (k == 0) ? bhe_n : ~bhe_n;
            bus_rnw_i   = (k == 0) ? rnw : ~rnw;
            bus_wdata_i = (k == wk) ? wd : ~wd;           // R4 only selected cycle valid
        end
        if (drop) begin
            chk({tag, " R3 dropped: no TA"}, ta_n, 0);
            chk({tag, " R3 dropped: no request"}, req_n, 0);
        end else begin
            chk({tag, " R5 single TA"}, ta_n, 1);
            chk({tag, " R5 TA cycle"}, ta_k, exp_k);
            if (rnw) chk({tag, " R6 read data"}, got, exp_rd);
            if (err) begin
                chk({tag, " R9 no request"}, req_n, 0);
                chk({tag, " R9 zero data"}, got, 16'h0);
                if (model_err < 255) model_err++;
            end else if (!rnw) begin
                if (be[0]) model_mem[addr[AW-1:1]][7:0]  = wd[7:0];
                if (be[1]) model_mem[addr[AW-1:1]][15:8] = wd[15:8];
            end
        end
        chk({tag, " R9 error count"}, err_cnt_o, model_err);
    endtask

    task automatic quiet_errs(input int n);
        for (int i = 0; i < n; i++) begin
            xfer(1'b0, 8'h11, 1'b1, 16'h0, 0, 1'b0, 1'b0, 0, "R10 sat loop");
        end
    endtask

    initial begin
        repeat (200000 - 50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model_mem[i] = 16'hA500 ^ 16'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready low after reset", ready_o, 0);
        chk("R1 ta oe low before ready", bus_ta_oe_o, 0);
        chk("R6 no TA at reset", bus_ta_o, 0);
        chk("R10 counter zero at reset", err_cnt_o, 0);

        // R1: strobe ignored before ready
        xfer(1'b0, 8'h04, 1'b0, 16'hDEAD, 0, 1'b0, 1'b0, 0, "R1 pre-ready write");
        load_done_i = 1'b1;
        @(negedge clk);
        load_done_i = 1'b0;
        chk("R1 ready after load done", ready_o, 1);
        @(negedge clk);
        chk("R1 ready sticky", ready_o, 1);
        chk("R1 ta oe driven", bus_ta_oe_o, 1);
        model_ready = 1;
        xfer(1'b1, 8'h04, 1'b0, 16'h0, 0, 1'b0, 1'b0, 0, "R1 readback unchanged");

        // R4 R7: early full write, read with late CS and slow grant
        xfer(1'b0, 8'h10, 1'b0, 16'h1234, 0, 1'b0, 1'b0, 0, "R4 early write");
        xfer(1'b1, 8'h10, 1'b0, 16'h0, 1, 1'b0, 1'b0, 2, "R3 late cs read");
        // R4: late data with late CS
        xfer(1'b0, 8'h20, 1'b0, 16'hBEEF, 1, 1'b1, 1'b0, 1, "R4 late write");
        xfer(1'b1, 8'h20, 1'b0, 16'h0, 0, 1'b1, 1'b0, 3, "R4 late readback");
        // R7: low byte only, high byte only
        xfer(1'b0, 8'h30, 1'b1, 16'h5A3C, 0, 1'b0, 1'b0, 0, "R7 low lane write");
        xfer(1'b0, 8'h41, 1'b0, 16'hC3A5, 1, 1'b1, 1'b0, 2, "R7 high lane write");
        // R8: forced 16-bit reads
        xfer(1'b1, 8'h30, 1'b1, 16'h0, 0, 1'b0, 1'b1, 0, "R8 forced read low");
        xfer(1'b1, 8'h41, 1'b0, 16'h0, 1, 1'b0, 1'b1, 1, "R8 forced read odd");
        // R6: masked partial reads
        xfer(1'b1, 8'h41, 1'b0, 16'h0, 0, 1'b0, 1'b0, 0, "R6 high lane read");
        xfer(1'b1, 8'h30, 1'b1, 16'h0, 1, 1'b0, 1'b0, 1, "R6 low lane read");
        // R9: errors
        xfer(1'b0, 8'h21, 1'b1, 16'hFFFF, 0, 1'b1, 1'b0, 0, "R9 error write");
        xfer(1'b1, 8'h21, 1'b1, 16'h0, 1, 1'b0, 1'b1, 0, "R9 error read");
        xfer(1'b1, 8'h20, 1'b0, 16'h0, 0, 1'b0, 1'b0, 0, "R9 target untouched");
        // R3: drop
        xfer(1'b0, 8'h50, 1'b0, 16'h7777, 2, 1'b0, 1'b0, 0, "R3 no cs");
        xfer(1'b1, 8'h50, 1'b0, 16'h0, 0, 1'b0, 1'b0, 0, "R3 drop left no write");
        // R10: saturation and clear
        quiet_errs(258);
        chk("R10 saturated", err_cnt_o, 255);
        @(negedge clk);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        model_err = 0;
        chk("R10 cleared", err_cnt_o, 0);
        xfer(1'b0, 8'h03, 1'b1, 16'h0, 1, 1'b0, 1'b0, 0, "R9 count after clear");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule